// File: doc/BRIEF.md
# Polled Serial Port Register Front End

This block sits between a processor bus and the shifting logic of a simple serial port. It answers four consecutive 32-bit word locations starting at a base address. The processor writes a byte to be sent into one location, reads a received byte from another, polls a status word, and sets transmission parameters, such as a baud divisor, in a control word. The control word is driven straight out to the shifting logic.

On the peripheral side, the block offers the pending output byte together with a ready indication. The shifting logic takes the byte with a one-cycle strobe, works on it, and reports completion with a done strobe. A byte that has been written but not yet taken is tracked by an internal ready flag. The processor cannot see this flag; it sees only the busy bit, which covers the time between a take and the matching done. Received bytes arrive through a valid strobe and are held until the processor reads them.

The transmit handoff is a four-state machine. TX_IDLE means nothing is pending and the port is not busy. TX_LOADED means a byte is pending and the port is not busy. TX_SENDING means the port is busy and nothing is pending. TX_SEND_LOADED means the port is busy and another byte is already pending. A write of the output byte moves TX_IDLE to TX_LOADED and TX_SENDING to TX_SEND_LOADED. A take moves TX_LOADED to TX_SENDING, and it also moves TX_SEND_LOADED to TX_SENDING, where the new byte replaces the finished one. A done moves TX_SENDING to TX_IDLE and TX_SEND_LOADED to TX_LOADED. When a write arrives in the same cycle as a take or a done, the state keeps a pending byte.

Top module: `serport_regs`

## Requirements
- R1: The block decodes four word locations from BASE_ADDR, which must be 16-byte aligned: +0x0 input data, +0x4 output data, +0x8 status, +0xC control. A read of any other address, including a misaligned one, returns 0, and a write to it changes nothing.
- R2: A write to the output data location drives `tx_byte` with bits [7:0] of the write data and raises `tx_ready` after that clock edge.
- R3: A `tx_take` while `tx_ready` is 1 lowers `tx_ready` after that edge, unless a new write lands in the same cycle. It also sets status bit 0 (busy).
- R4: Status bit 0 stays 1 until `tx_done` is seen, and reads 0 after the edge that samples `tx_done`.
- R5: The ready flag appears in no readable word. Status bits 31..2 always read 0, and a written but untaken byte leaves status bit 0 at 0.
- R6: A `tx_take` while `tx_ready` is 0 has no effect. A `tx_done` while not busy has no effect.
- R7: A write while busy leaves busy at 1 and raises `tx_ready` with the new byte. The following `tx_done` clears busy and keeps `tx_ready` at 1.
- R8: An `rx_valid` strobe stores `rx_byte` (readable in bits [7:0] of input data) and sets status bit 1. A read of input data clears bit 1 after that edge, unless `rx_valid` arrives in the same cycle, in which case the new byte is kept with bit 1 set.
- R9: The control location is read/write in bits [15:0]. It drives `ctrl_out` and resets to CTRL_RESET.
- R10: Writes to the input data and status locations are ignored. A read of output data returns the last written byte.
- R11: After reset, `tx_ready` is 0, status reads 0, and `ctrl_out` equals CTRL_RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; qualifies bus_rdata and clears receive-available |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no decoded read |
| tx_byte | output | 8 | Byte offered to the shifter |
| tx_ready | output | 1 | A byte is pending for the shifter |
| tx_take | input | 1 | Shifter takes the pending byte |
| tx_done | input | 1 | Shifter has finished the byte it took |
| rx_valid | input | 1 | A received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| ctrl_out | output | 16 | Transmission parameter word |

## Verification
The hardest state to reach is TX_SEND_LOADED, where a byte is in flight and a second one is pending. From there, done and take must each act on the right byte. The bench gets there by writing a byte, taking it, and writing a second byte before `tx_done`. It then checks busy and ready separately through the status word and `tx_ready` after each strobe. The read-versus-receive collision is reached by holding a read of input data in the same cycle as an `rx_valid` strobe.

// File: rtl/serport_pkg.sv
package serport_pkg;
    typedef enum logic [1:0] {
        TX_IDLE        = 2'd0,
        TX_LOADED      = 2'd1,
        TX_SENDING     = 2'd2,
        TX_SEND_LOADED = 2'd3
    } tx_state_e;

    // word index inside the four-location window; order is decoded
    typedef enum logic [1:0] {
        LOC_IN   = 2'd0,
        LOC_OUT  = 2'd1,
        LOC_STAT = 2'd2,
        LOC_CTRL = 2'd3
    } loc_e;

    localparam int NUM_LOCS = 4;
endpackage

// File: rtl/serport_decode.sv
module serport_decode
    import serport_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic                rd,
    output logic [NUM_LOCS-1:0] wr_sel,
    output logic [NUM_LOCS-1:0] rd_sel
);
    logic hit;
    assign hit = (addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]) && (addr[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_LOCS; i++) begin : g_loc
        assign wr_sel[i] = wr && hit && (addr[3:2] == 2'(i));
        assign rd_sel[i] = rd && hit && (addr[3:2] == 2'(i));
    end
endmodule

// File: rtl/serport_txhand.sv
module serport_txhand
    import serport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic take,
    input  logic done,
    output logic ready,
    output logic busy
);
    tx_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:        if (load) state_nx = TX_LOADED;
            TX_LOADED:      if (take) state_nx = load ? TX_SEND_LOADED : TX_SENDING;
            TX_SENDING: begin
                if (done)      state_nx = load ? TX_LOADED : TX_IDLE;
                else if (load) state_nx = TX_SEND_LOADED;
            end
            TX_SEND_LOADED: begin
                if (take)      state_nx = load ? TX_SEND_LOADED : TX_SENDING;
                else if (done) state_nx = TX_LOADED;
            end
            default:        state_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        ready = 1'b0;
        busy  = 1'b0;
        unique case (state)
            TX_IDLE:        ;
            TX_LOADED:      ready = 1'b1;
            TX_SENDING:     busy  = 1'b1;
            TX_SEND_LOADED: begin ready = 1'b1; busy = 1'b1; end
            default:        ;
        endcase
    end
endmodule

// File: rtl/serport_rxhold.sv
module serport_rxhold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rd_clear,
    output logic [DATA_W-1:0] data,
    output logic              avail
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            avail <= 1'b0;
        end else if (rx_valid) begin
            data  <= rx_byte;
            avail <= 1'b1;
        end else if (rd_clear) begin
            avail <= 1'b0;
        end
    end
endmodule

// File: rtl/serport_regs.sv
module serport_regs
    import serport_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8,
    parameter int CTRL_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 12'h100,
    parameter logic [CTRL_W-1:0] CTRL_RESET = 16'h0138
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_ready,
    input  logic              tx_take,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [CTRL_W-1:0] ctrl_out
);
    localparam int STAT_W = 2;

    logic [NUM_LOCS-1:0] wr_sel, rd_sel;
    logic [DATA_W-1:0]   out_q, in_data;
    logic [CTRL_W-1:0]   ctrl_q;
    logic                busy, rx_avail, ready_w;
    logic                unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:CTRL_W];

    serport_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wr_sel(wr_sel), .rd_sel(rd_sel)
    );

    serport_txhand u_tx (
        .clk(clk), .rst_n(rst_n), .load(wr_sel[LOC_OUT]), .take(tx_take),
        .done(tx_done), .ready(ready_w), .busy(busy)
    );

    serport_rxhold #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rd_clear(rd_sel[LOC_IN]), .data(in_data), .avail(rx_avail)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            ctrl_q <= CTRL_RESET;
        end else begin
            if (wr_sel[LOC_OUT])  out_q  <= bus_wdata[DATA_W-1:0];
            if (wr_sel[LOC_CTRL]) ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (1'b1)
            rd_sel[LOC_IN]:   bus_rdata = BUS_W'(in_data);
            rd_sel[LOC_OUT]:  bus_rdata = BUS_W'(out_q);
            rd_sel[LOC_STAT]: bus_rdata = BUS_W'({rx_avail, busy});
            rd_sel[LOC_CTRL]: bus_rdata = BUS_W'(ctrl_q);
            default:          bus_rdata = '0;
        endcase
    end

    assign tx_byte  = out_q;
    assign tx_ready = ready_w;
    assign ctrl_out = ctrl_q;

    if (STAT_W != 2) begin : g_bad_stat
        $error("status width mismatch");
    end
endmodule

// File: rtl/serport_regs_chk.sv
module serport_regs_chk #(
    parameter int ADDR_W = 12,
    parameter int CTRL_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              tx_ready,
    input logic              tx_take,
    input logic              tx_done,
    input logic              rx_valid,
    input logic              busy,
    input logic              rx_avail,
    input logic [CTRL_W-1:0] ctrl_out
);
    logic wr_out, wr_ctrl;
    assign wr_out  = bus_wr && (bus_addr == BASE_ADDR + ADDR_W'(4));
    assign wr_ctrl = bus_wr && (bus_addr == BASE_ADDR + ADDR_W'(12));

    AST_WRITE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> tx_ready);                                              // R2
    AST_TAKE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_take && !wr_out) |=> !tx_ready);                   // R3
    AST_TAKE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_take) |=> busy);                                   // R3
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_done) |=> busy);                                      // R4
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tx_done && !(tx_ready && tx_take)) |=> !busy);            // R4
    AST_NO_READY_FROM_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && !wr_out) |=> !tx_ready);                             // R6
    AST_NO_BUSY_FROM_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(tx_ready && tx_take)) |=> !busy);                      // R6
    AST_RX_SETS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_avail);                                            // R8
    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(ctrl_out));                                   // R9
endmodule

bind serport_regs serport_regs_chk #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .tx_ready(tx_ready), .tx_take(tx_take), .tx_done(tx_done),
    .rx_valid(rx_valid), .busy(busy), .rx_avail(rx_avail), .ctrl_out(ctrl_out)
);

// File: tb/serport_regs_test.sv
module serport_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_IN   = 12'h100;
    localparam logic [11:0] A_OUT  = 12'h104;
    localparam logic [11:0] A_STAT = 12'h108;
    localparam logic [11:0] A_CTRL = 12'h10C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_ready;
    logic        tx_take = 1'b0, tx_done = 1'b0, rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [15:0] ctrl_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serport_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .tx_take(tx_take), .tx_done(tx_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ctrl_out(ctrl_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_take();
        @(negedge clk); tx_take = 1'b1;
        @(posedge clk); #1 tx_take = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(posedge clk); #1 tx_done = 1'b0;
    endtask

    task automatic pulse_rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #1 rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R11 tx_ready", 32'(tx_ready), 0);
        chk("R11 ctrl_out", 32'(ctrl_out), 32'h0138);
        bread(A_STAT, d); chk("R11 status", d, 0);
        chk("R11 idle rdata", bus_rdata, 0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        bwrite(12'h114, 32'h5A);
        chk("R1 outside write no ready", 32'(tx_ready), 0);
        bwrite(12'h105, 32'h5A);
        chk("R1 misaligned write no ready", 32'(tx_ready), 0);
        bread(12'h10C, d); chk("R1 ctrl location", d, 32'h0138);
        bread(12'h110, d); chk("R1 outside read zero", d, 0);
        bread(12'h00C, d); chk("R1 other base read zero", d, 0);
    endtask

    task automatic t_tx_basic();
        logic [31:0] d;
        bwrite(A_OUT, 32'hFFFF_FFA5);
        chk("R2 tx_ready", 32'(tx_ready), 1);
        chk("R2 tx_byte", 32'(tx_byte), 32'hA5);
        bread(A_STAT, d); chk("R5 ready hidden in status", d, 0);
        pulse_take();
        chk("R3 ready cleared", 32'(tx_ready), 0);
        bread(A_STAT, d); chk("R3 busy set", d, 1);
        repeat (3) @(posedge clk);
        bread(A_STAT, d); chk("R4 busy held", d, 1);
        pulse_done();
        bread(A_STAT, d); chk("R4 busy cleared", d, 0);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        pulse_take();
        chk("R6 take without ready", 32'(tx_ready), 0);
        bread(A_STAT, d); chk("R6 take without ready no busy", d, 0);
        pulse_done();
        bread(A_STAT, d); chk("R6 done while idle", d, 0);
        chk("R6 done while idle ready", 32'(tx_ready), 0);
    endtask

    task automatic t_queue();
        logic [31:0] d;
        bwrite(A_OUT, 32'h11);
        pulse_take();
        bwrite(A_OUT, 32'h22);
        chk("R7 queued ready", 32'(tx_ready), 1);
        chk("R7 queued byte", 32'(tx_byte), 32'h22);
        bread(A_STAT, d); chk("R7 still busy", d, 1);
        pulse_done();
        bread(A_STAT, d); chk("R7 done clears busy", d, 0);
        chk("R7 ready kept", 32'(tx_ready), 1);
        pulse_take();
        chk("R3 second take", 32'(tx_ready), 0);
        pulse_done();
        bread(A_STAT, d); chk("R4 second done", d, 0);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        pulse_rx(8'h3C);
        bread(A_STAT, d); chk("R8 avail set", d, 2);
        bread(A_IN, d);   chk("R8 data", d, 32'h3C);
        bread(A_STAT, d); chk("R8 avail cleared", d, 0);
        pulse_rx(8'h77);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = A_IN; rx_valid = 1'b1; rx_byte = 8'h99;
        #1 chk("R8 old byte on collision", bus_rdata, 32'h77);
        @(posedge clk); #1 bus_rd = 1'b0; rx_valid = 1'b0;
        bread(A_STAT, d); chk("R8 collision keeps avail", d, 2);
        bread(A_IN, d);   chk("R8 collision new byte", d, 32'h99);
        bread(A_STAT, d); chk("R8 cleared after", d, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        bwrite(A_CTRL, 32'hDEAD_BEEF);
        chk("R9 ctrl_out", 32'(ctrl_out), 32'hBEEF);
        bread(A_CTRL, d); chk("R9 ctrl read", d, 32'hBEEF);
    endtask

    task automatic t_ro_writes();
        logic [31:0] d;
        pulse_rx(8'h42);
        bwrite(A_IN, 32'hEE);
        bwrite(A_STAT, 32'hFFFF_FFFF);
        bread(A_STAT, d); chk("R10 status write ignored", d, 2);
        bread(A_IN, d);   chk("R10 input write ignored", d, 32'h42);
        chk("R10 no side effect ready", 32'(tx_ready), 0);
        bwrite(A_OUT, 32'h6B);
        bread(A_OUT, d);  chk("R10 output readback", d, 32'h6B);
        pulse_take(); pulse_done();
        bread(A_OUT, d);  chk("R10 readback after send", d, 32'h6B);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_decode();
        t_tx_basic();
        t_ignore();
        t_queue();
        t_rx();
        t_ctrl();
        t_ro_writes();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule